// File: doc/BRIEF.md
# Coast window generator

This block produces a single active-high coast flag that tells a downstream clock-recovery loop to stop tracking horizontal sync around the vertical blanking interval. It runs in the pixel clock domain. Its inputs are a one-cycle horizontal sync strobe per line, a vertical sync level that is already active high, an external coast input, and a small set of static control fields.

In internal mode the flag is built from vertical sync. It rises a programmed number of lines before vertical sync and stays up until a programmed number of lines after it. Vertical sync cannot be seen ahead of time, so the block counts the strobes in each frame and keeps that total. In the next frame it raises coast once the running line count comes close enough to the stored total. Until one whole frame has been measured, no early window is applied and coast starts with vertical sync.

In external mode the block passes the external coast input through after resolving its polarity. The polarity is either forced by a control field or found automatically. The automatic detector assumes the coast input sits at its idle level most of the time.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `coast_out` is low when the source is internal and `vsync_in` has been low.
- R2: In internal mode, `coast_out` is high in every cycle that follows a cycle in which `vsync_in` was sampled high.
- R3: In internal mode, when `vsync_in` falls, a countdown is loaded with `cfg_post_lines`. A strobe in the same cycle as the fall is not counted, and each later strobe decrements the countdown. Coast stays high while the countdown is non-zero. With `cfg_post_lines` = 0, coast drops in the cycle after `vsync_in` was first sampled low.
- R4: The line count is the number of strobes since the last rising edge of `vsync_in`, including a strobe in the rising-edge cycle. The frame total is the line count just before a rising edge. With `cfg_pre_lines` = P > 0 and stored total T, coast rises in the cycle after the strobe that makes the line count reach T−P or more (every line if P ≥ T−1).
- R5: Pre-coast is applied only after two rising edges of `vsync_in` have been seen since reset. Before that, internal coast comes only from vertical sync and the post countdown.
- R6: `cfg_pre_lines` = 0 disables the early window entirely.
- R7: With `cfg_src_ext` = 1 and `cfg_pol_force` = 1, `coast_out` equals `ext_coast_in` from the previous cycle if `cfg_pol_high` = 1, and its inverse if `cfg_pol_high` = 0.
- R8: With `cfg_pol_force` = 0, a saturating counter (range −7..+7, reset 0) moves up at each strobe while the registered external input is high, and down while it is low. The input is taken as active high when the counter is ≤ 0, and as active low otherwise.
- R9: With `cfg_src_ext` = 1, `vsync_in` has no effect on `coast_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_strobe | input | 1 | One-cycle pulse at each line start |
| vsync_in | input | 1 | Vertical sync level, active high |
| ext_coast_in | input | 1 | External coast, polarity unresolved |
| cfg_src_ext | input | 1 | 0 = coast built from vertical sync, 1 = external input |
| cfg_pol_force | input | 1 | 1 = external polarity taken from cfg_pol_high |
| cfg_pol_high | input | 1 | Forced external polarity, 1 = active high |
| cfg_pre_lines | input | 8 | Lines of coast ahead of vertical sync |
| cfg_post_lines | input | 8 | Lines of coast after vertical sync ends |
| coast_out | output | 1 | Coast flag, active high |

## Verification
The assertions check four things every cycle: that coast follows vertical sync with one cycle of delay, that coast drops at once when both counts are zero, that there is no early window before any frame start, and that the forced-polarity external path is correct. The bench alone can show that the early window lands on the right line of a frame. That depends on the total measured in the frame before, so random frame lengths, sync widths and counts are played line by line and compared with a per-line expectation. The same holds for the automatic polarity detector's saturation and its switch-over point, which are driven in directed strobe sequences.

// File: rtl/coast_pkg.sv
package coast_pkg;

    typedef struct packed {
        logic       src_ext;
        logic       pol_force;
        logic       pol_high;
        logic [7:0] pre_lines;
        logic [7:0] post_lines;
    } coast_cfg_t;

    typedef enum logic [1:0] {
        TRK_NONE  = 2'd0,
        TRK_FIRST = 2'd1,
        TRK_VALID = 2'd2
    } trk_state_e;

    function automatic logic pre_reached(input logic [15:0] cnt,
                                         input logic [15:0] total,
                                         input logic [15:0] pre);
        logic [16:0] sum;
        sum = {1'b0, cnt} + {1'b0, pre};
        return (pre != 16'd0) && (sum >= {1'b0, total});
    endfunction

endpackage

// File: rtl/coast_line_tracker.sv
module coast_line_tracker
    import coast_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs,
    input  logic             vs_rise,
    input  logic [CNT_W-1:0] pre_lines,
    output logic             pre_hit
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] total;
    trk_state_e        st;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
            total    <= '0;
            st       <= TRK_NONE;
        end else if (vs_rise) begin
            total    <= line_cnt;
            line_cnt <= hs ? LINE_W'(1) : '0;
            st       <= (st == TRK_NONE) ? TRK_FIRST : TRK_VALID;
        end else if (hs && line_cnt != LINE_MAX) begin
            line_cnt <= line_cnt + LINE_W'(1);
        end
    end

    always_comb begin
        pre_hit = (st == TRK_VALID) &&
                  pre_reached(16'(line_cnt), 16'(total), 16'(pre_lines));
    end
endmodule

// File: rtl/coast_post_timer.sv
module coast_post_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs,
    input  logic             vs_fall,
    input  logic [CNT_W-1:0] post_lines,
    output logic             post_active
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (vs_fall) begin
            remain <= post_lines;
        end else if (hs && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign post_active = (remain != '0);
endmodule

// File: rtl/coast_ext_polarity.sv
module coast_ext_polarity #(
    parameter int ACC_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hs,
    input  logic ext_in,
    input  logic pol_force,
    input  logic pol_high,
    output logic coast_ext
);
    localparam int              ACC_LIM = (1 << (ACC_W - 1)) - 1;
    localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(ACC_LIM);
    localparam logic [ACC_W-1:0] ACC_BOT = ACC_W'(-ACC_LIM);

    logic             ext_q;
    logic [ACC_W-1:0] acc;
    logic             auto_high;
    logic             act_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            acc   <= '0;
        end else begin
            ext_q <= ext_in;
            if (hs) begin
                if (ext_q && acc != ACC_TOP) begin
                    acc <= acc + ACC_W'(1);
                end else if (!ext_q && acc != ACC_BOT) begin
                    acc <= acc - ACC_W'(1);
                end
            end
        end
    end

    always_comb begin
        auto_high = acc[ACC_W-1] || (acc == '0);
        act_high  = pol_force ? pol_high : auto_high;
        coast_ext = (ext_q == act_high);
    end
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
    import coast_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int ACC_W  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_strobe,
    input  logic       vsync_in,
    input  logic       ext_coast_in,
    input  logic       cfg_src_ext,
    input  logic       cfg_pol_force,
    input  logic       cfg_pol_high,
    input  logic [7:0] cfg_pre_lines,
    input  logic [7:0] cfg_post_lines,
    output logic       coast_out
);
    localparam int CNT_W = 8;

    coast_cfg_t cfg;
    logic       vs_q;
    logic       vs_rise;
    logic       vs_fall;
    logic       pre_hit;
    logic       post_active;
    logic       coast_ext;
    logic       coast_int;

    assign cfg = '{src_ext:    cfg_src_ext,
                   pol_force:  cfg_pol_force,
                   pol_high:   cfg_pol_high,
                   pre_lines:  cfg_pre_lines,
                   post_lines: cfg_post_lines};

    always_ff @(posedge clk) begin
        if (rst) vs_q <= 1'b0;
        else     vs_q <= vsync_in;
    end

    assign vs_rise = vsync_in && !vs_q;
    assign vs_fall = !vsync_in && vs_q;

    coast_line_tracker #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .hs        (hs_strobe),
        .vs_rise   (vs_rise),
        .pre_lines (cfg.pre_lines),
        .pre_hit   (pre_hit)
    );

    coast_post_timer #(.CNT_W(CNT_W)) u_post (
        .clk         (clk),
        .rst         (rst),
        .hs          (hs_strobe),
        .vs_fall     (vs_fall),
        .post_lines  (cfg.post_lines),
        .post_active (post_active)
    );

    coast_ext_polarity #(.ACC_W(ACC_W)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .hs        (hs_strobe),
        .ext_in    (ext_coast_in),
        .pol_force (cfg.pol_force),
        .pol_high  (cfg.pol_high),
        .coast_ext (coast_ext)
    );

    assign coast_int = vs_q || post_active || pre_hit;
    assign coast_out = cfg.src_ext ? coast_ext : coast_int;
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk (
    input logic       clk,
    input logic       rst,
    input logic       hs_strobe,
    input logic       vsync_in,
    input logic       ext_coast_in,
    input logic       cfg_src_ext,
    input logic       cfg_pol_force,
    input logic       cfg_pol_high,
    input logic [7:0] cfg_pre_lines,
    input logic [7:0] cfg_post_lines,
    input logic       coast_out
);
    logic vs_prev;
    logic rise_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev   <= 1'b0;
            rise_seen <= 1'b0;
        end else begin
            vs_prev <= vsync_in;
            if (vsync_in && !vs_prev) rise_seen <= 1'b1;
        end
    end

    AST_VS_DRIVES_COAST: assert property (@(posedge clk) disable iff (rst)
        (!cfg_src_ext && vs_prev) |-> coast_out); // R2

    AST_ZERO_POST_DROP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_src_ext && cfg_pre_lines == 8'd0 && $past(cfg_post_lines) == 8'd0
         && $past(vsync_in, 2) && !$past(vsync_in)) |-> !coast_out); // R3

    AST_NO_EARLY_BEFORE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!cfg_src_ext && !rise_seen && !vs_prev) |-> !coast_out); // R5

    AST_FORCED_EXT_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (cfg_src_ext && cfg_pol_force && $past(!rst))
        |-> (coast_out == ($past(ext_coast_in) == cfg_pol_high))); // R7
endmodule

bind coast_window_gen coast_window_chk u_chk (.*);

// File: tb/coast_window_gen_bench.sv
module coast_window_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_strobe = 1'b0;
    logic       vsync_in = 1'b0;
    logic       ext_coast_in = 1'b0;
    logic       cfg_src_ext = 1'b0;
    logic       cfg_pol_force = 1'b0;
    logic       cfg_pol_high = 1'b1;
    logic [7:0] cfg_pre_lines = 8'd0;
    logic [7:0] cfg_post_lines = 8'd0;
    logic       coast_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam int LINE_LEN = 8;
    localparam int SAMPLE_AT = 4;

    always #2 clk = ~clk;

    coast_window_gen u_coast_window_gen (.*);

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: coast_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected internal coast for line k of a frame (R2..R6)
    function automatic logic exp_line(input int k, input int v, input int q,
                                      input int p, input int tot, input bit valid);
        logic early;
        early = valid && (p > 0) && (k >= tot - 1 - p);
        return (k < v + q) || early;
    endfunction

    task automatic play_line(input logic vs, input logic exp, input string req);
        for (int c = 0; c < LINE_LEN; c++) begin
            @(negedge clk);
            if (c == SAMPLE_AT) check(req, coast_out, exp);
            hs_strobe = (c == 0);
            vsync_in  = vs;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hs_strobe = 1'b0;
        vsync_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", coast_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", coast_out, 1'b0);
    endtask

    task automatic strobes(input int n, input logic lvl);
        @(negedge clk);
        ext_coast_in = lvl;
        hs_strobe = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); hs_strobe = 1'b1;
            @(negedge clk); hs_strobe = 1'b0;
        end
    endtask

    task automatic probe_ext(input logic lvl, input logic exp, input string req);
        @(negedge clk);
        ext_coast_in = lvl;
        vsync_in = ~vsync_in;
        @(negedge clk);
        check(req, coast_out, exp);
    endtask

    initial begin
        int acc;
        int prev_n;
        void'($urandom(32'h00C0A575));

        // ---------------- internal mode ----------------
        do_reset();
        // idle lines before any frame: no early window (R5)
        for (int k = 0; k < 5; k++) play_line(1'b0, 1'b0, "R5");
        prev_n = 0;
        for (int f = 0; f < 14; f++) begin
            int n, v, q, p;
            n = 12 + int'($urandom_range(18));
            v = 1 + int'($urandom_range(2));
            q = int'($urandom_range(5));
            p = int'($urandom_range(6));
            if (f == 3) begin p = 0; q = 0; end    // R6 / R3 zero case
            if (f == 6) p = prev_n - 1;             // R4 whole-frame window
            if (f == 8) p = 0;                      // R6
            cfg_pre_lines  = 8'(p);
            cfg_post_lines = 8'(q);
            for (int k = 0; k < n; k++) begin
                string tag;
                tag = (k < v) ? "R2" : (k < v + q) ? "R3" :
                      (f == 0) ? "R5" : (p == 0) ? "R6" : "R4";
                play_line(k < v, exp_line(k, v, q, p, prev_n, f >= 1), tag);
            end
            prev_n = n;
        end

        // ---------------- external, forced polarity ----------------
        do_reset();
        cfg_src_ext   = 1'b1;
        cfg_pol_force = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic lvl;
            lvl = 1'($urandom_range(1));
            cfg_pol_high = 1'($urandom_range(1));
            probe_ext(lvl, lvl == cfg_pol_high, "R7");
        end
        // vsync held high then low while external: no effect (R9)
        cfg_pol_high = 1'b1;
        @(negedge clk); ext_coast_in = 1'b0; vsync_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", coast_out, 1'b0);

        // ---------------- external, automatic polarity ----------------
        do_reset();
        cfg_src_ext   = 1'b1;
        cfg_pol_force = 1'b0;
        acc = 0;
        probe_ext(1'b1, 1'b1, "R8");   // reset counter 0 -> active high
        probe_ext(1'b0, 1'b0, "R8");
        strobes(10, 1'b1);             // saturates at +7 -> active low
        acc = 7;
        probe_ext(1'b0, acc <= 0 ? 1'b0 : 1'b1, "R8");
        probe_ext(1'b1, acc <= 0 ? 1'b1 : 1'b0, "R8");
        strobes(6, 1'b0);              // +1, still active low
        acc = 1;
        probe_ext(1'b0, acc <= 0 ? 1'b0 : 1'b1, "R8");
        strobes(1, 1'b0);              // 0 -> active high
        acc = 0;
        probe_ext(1'b1, acc <= 0 ? 1'b1 : 1'b0, "R8");
        probe_ext(1'b0, acc <= 0 ? 1'b0 : 1'b1, "R8");
        strobes(12, 1'b0);             // saturates at -7
        strobes(7, 1'b1);              // back to 0 -> active high
        probe_ext(1'b1, 1'b1, "R8");
        strobes(1, 1'b1);              // +1 -> active low
        probe_ext(1'b1, 1'b0, "R8");
        cfg_pol_force = 1'b1;          // force overrides detector (R7)
        probe_ext(1'b1, 1'b1, "R7");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule